// File: doc/BRIEF.md
# Isochronous receive context control register

This block is the control and status word for one isochronous receive DMA context. Software changes it through two write strobes. One carries a set-mask and the other a clear-mask, so any bit can be changed without a read-modify-write. Hardware events from the context engine change it as well: descriptor fetches, fatal errors, the context becoming active, and completed packets. The word holds four mode bits that choose how packets are stored and when the context may start. It also holds the run, wake, dead and active handshake bits, the speed at which the last packet arrived, and the completion code of the last packet.

The block compares a 15-bit match value with the running cycle timer. This comparison decides whether a running context is allowed to begin. The match value is the two low bits of the seconds count followed by the 13-bit cycle count. The mode bits are frozen while the context runs or is active. A separate flag reports the illegal combination in which multi-channel reception is chosen without buffer-fill storage. The engine that fetches descriptors and moves data sits outside this block and reads `ctx_go` and `rd_data`.

Top module: `irx_ctx_ctrl`

## Requirements
- R1: After `rst_n` is low, `rd_data` reads zero. The register layout is fixed:
  - bit 31: buffer-fill mode
  - bit 30: keep header
  - bit 29: cycle-match enable
  - bit 28: multi-channel mode
  - bit 15: run
  - bit 12: wake
  - bit 11: dead
  - bit 10: active
  - bits 7:5: speed
  - bits 4:0: event code
  - bits 27:16, 14:13 and 9:8 always read zero.
- R2: A one in the set-mask sets the named bit. A one in the clear-mask clears it. Zeros leave the bit unchanged. When both masks name the same bit in one cycle, the clear wins.
- R3: Only software writes change run. `soft_rst` clears run, wake, dead and active on the next edge, ahead of any other update.
- R4: `desc_fetch` clears wake. This clear wins over a software set of wake in the same cycle.
- R5: `fatal_err` sets dead. A software clear of run clears dead, and it wins over a fatal error in the same cycle. Software writes to the dead bit have no effect.
- R6: `ctx_activated` sets active only while run stays set and dead stays clear. Active drops when run is cleared or dead is set. Software writes to the active bit have no effect.
- R7: While run or active is set before the edge, writes to the four mode bits are ignored. While both are clear, the mode bits follow R2.
- R8: `ctx_activated` clears cycle-match enable. This clear wins over a software set in the same cycle.
- R9: `ctx_go` is high when all of the following hold:
  - run is set;
  - dead is clear;
  - cycle-match enable is clear, or `match_value` equals {`cyc_sec_lo`, `cyc_count`}.
- R10: Speed and event code load from `pkt_speed` and `pkt_event` on `pkt_done` and hold otherwise. Speed codes are 000 for 100 Mb/s, 001 for 200 Mb/s and 010 for 400 Mb/s, and the block stores any code unchanged. Software writes to these bits have no effect.
- R11: `illegal_mode` is high exactly when multi-channel mode is set and buffer-fill mode is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset pulse for the handshake bits |
| wr_set_en | input | 1 | Set-mask write strobe |
| wr_set_data | input | 32 | Set-mask |
| wr_clr_en | input | 1 | Clear-mask write strobe |
| wr_clr_data | input | 32 | Clear-mask |
| rd_data | output | 32 | Current register value |
| match_value | input | SEC_KEEP+CNT_W | Cycle value at which a gated context may start |
| cyc_sec_lo | input | SEC_KEEP | Low bits of the cycle timer's seconds count |
| cyc_count | input | CNT_W | Cycle timer's cycle count |
| desc_fetch | input | 1 | Descriptor fetch event |
| fatal_err | input | 1 | Fatal error event |
| ctx_activated | input | 1 | Context became active |
| pkt_done | input | 1 | Packet completed |
| pkt_speed | input | 3 | Speed of the completed packet |
| pkt_event | input | 5 | Completion code of the completed packet |
| ctx_go | output | 1 | Context may run now |
| illegal_mode | output | 1 | Illegal mode combination |

## Verification
The bench builds the block with its default widths: two seconds bits and a 13-bit cycle count, which give a 15-bit match value. With these widths the bench can move the cycle count across the match point and show `ctx_go` rising. It can also keep the cycle count equal to the match while changing only a seconds bit, which shows that the seconds bits take part in the comparison. The random phase confines the cycle timer to a narrow window around one match value, so that gated starts occur often. Meanwhile writes, software resets and hardware events collide in the same cycles.

// File: rtl/irx_ctx_pkg.sv
package irx_ctx_pkg;

  localparam int REG_W      = 32;
  localparam int BIT_BFILL  = 31;
  localparam int BIT_HDR    = 30;
  localparam int BIT_CME    = 29;
  localparam int BIT_MULTI  = 28;
  localparam int MODE_LSB   = 28;
  localparam int MODE_N     = 4;
  localparam int BIT_RUN    = 15;
  localparam int BIT_WAKE   = 12;
  localparam int BIT_DEAD   = 11;
  localparam int BIT_ACTIVE = 10;
  localparam int SPD_LSB    = 5;
  localparam int SPD_W      = 3;
  localparam int EVT_LSB    = 0;
  localparam int EVT_W      = 5;

  // index of each mode bit inside the 4-bit mode vector
  localparam int MI_MULTI = BIT_MULTI - MODE_LSB;
  localparam int MI_CME   = BIT_CME   - MODE_LSB;
  localparam int MI_HDR   = BIT_HDR   - MODE_LSB;
  localparam int MI_BFILL = BIT_BFILL - MODE_LSB;

  // one bit after a set/clear write; clear dominates
  function automatic logic apply_sc(input logic cur, input logic set_b, input logic clr_b);
    return (cur | set_b) & ~clr_b;
  endfunction

endpackage

// File: rtl/irx_mode_bits.sv
module irx_mode_bits #(
  parameter int N = 4,
  parameter logic [N-1:0] HW_CLR_MASK = 4'b0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  input  logic         hw_clr,
  output logic [N-1:0] mode_q
);
  import irx_ctx_pkg::*;

  logic [N-1:0] sw_next;
  logic [N-1:0] mode_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      sw_next[i] = lock ? mode_q[i] : apply_sc(mode_q[i], set_v[i], clr_v[i]);
      if (HW_CLR_MASK[i]) mode_d[i] = sw_next[i] & ~hw_clr;
      else                mode_d[i] = sw_next[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  // R7: bits without a hardware clear are frozen while locked
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ((mode_q & ~HW_CLR_MASK) == ($past(mode_q) & ~HW_CLR_MASK)));

  // R8: hardware clear always lands
  a_r8_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> ((mode_q & HW_CLR_MASK) == '0));

endmodule

// File: rtl/irx_handshake.sv
module irx_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic sw_set_run,
  input  logic sw_clr_run,
  input  logic sw_set_wake,
  input  logic sw_clr_wake,
  input  logic hw_fetch,
  input  logic hw_fatal,
  input  logic hw_activated,
  output logic run_q,
  output logic wake_q,
  output logic dead_q,
  output logic active_q
);
  import irx_ctx_pkg::*;

  logic run_d, wake_d, dead_d, active_d;
  logic run_clr_evt;
  logic wake_clr_evt;

  assign run_clr_evt  = sw_clr_run;
  assign wake_clr_evt = sw_clr_wake | hw_fetch;

  always_comb begin
    if (soft_rst) begin
      run_d    = 1'b0;
      wake_d   = 1'b0;
      dead_d   = 1'b0;
      active_d = 1'b0;
    end else begin
      run_d    = apply_sc(run_q,  sw_set_run,  run_clr_evt);
      wake_d   = apply_sc(wake_q, sw_set_wake, wake_clr_evt);
      dead_d   = apply_sc(dead_q, hw_fatal,    run_clr_evt);
      active_d = run_d & ~dead_d & (active_q | hw_activated);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      wake_q   <= 1'b0;
      dead_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      wake_q   <= wake_d;
      dead_q   <= dead_d;
      active_q <= active_d;
    end
  end

  // R3: run never rises without a software set
  a_r3_run_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !sw_set_run) |=> !run_q);

  // R3: soft reset empties the handshake bits
  a_r3_soft_rst: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !(run_q | wake_q | dead_q | active_q));

  // R4: a fetch leaves wake clear
  a_r4_fetch_clears_wake: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fetch |=> !wake_q);

  // R5: fatal error marks dead unless run is being cleared
  a_r5_fatal_sets_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fatal && !sw_clr_run && !soft_rst) |=> dead_q);

  // R5: clearing run clears dead
  a_r5_run_clr_dead: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_run |=> !dead_q);

  // R6: active only with run set and dead clear
  a_r6_active_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (run_q && !dead_q));

endmodule

// File: rtl/irx_cycle_gate.sv
module irx_cycle_gate #(
  parameter int SEC_KEEP = 2,
  parameter int CNT_W    = 13,
  localparam int MATCH_W = SEC_KEEP + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MATCH_W-1:0] match_value,
  input  logic [SEC_KEEP-1:0] cyc_sec_lo,
  input  logic [CNT_W-1:0]   cyc_count,
  input  logic               run,
  input  logic               dead,
  input  logic               cme,
  output logic               hit,
  output logic               go
);

  function automatic logic [MATCH_W-1:0] cycle_key(input logic [SEC_KEEP-1:0] s,
                                                   input logic [CNT_W-1:0] c);
    return {s, c};
  endfunction

  assign hit = (cycle_key(cyc_sec_lo, cyc_count) == match_value);
  assign go  = run & ~dead & (~cme | hit);

  // R9: an ungated running context is always allowed to go
  a_r9_ungated_go: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dead && !cme) |-> go);

  // R9: a dead or stopped context never goes
  a_r9_stopped_no_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || dead) |-> !go);

endmodule

// File: rtl/irx_status_fields.sv
module irx_status_fields #(
  parameter int SW = 3,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_done,
  input  logic [SW-1:0] pkt_speed,
  input  logic [EW-1:0] pkt_event,
  output logic [SW-1:0] speed_q,
  output logic [EW-1:0] event_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
      event_q <= '0;
    end else if (pkt_done) begin
      speed_q <= pkt_speed;
      event_q <= pkt_event;
    end
  end

  // R10: fields hold between completions
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |=> ($stable(speed_q) && $stable(event_q)));

  // R10: fields capture on completion
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> (speed_q == $past(pkt_speed) && event_q == $past(pkt_event)));

endmodule

// File: rtl/irx_ctx_ctrl.sv
module irx_ctx_ctrl #(
  parameter int SEC_KEEP = 2,
  parameter int CNT_W    = 13,
  localparam int MATCH_W = SEC_KEEP + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                wr_set_en,
  input  logic [31:0]         wr_set_data,
  input  logic                wr_clr_en,
  input  logic [31:0]         wr_clr_data,
  output logic [31:0]         rd_data,
  input  logic [MATCH_W-1:0]  match_value,
  input  logic [SEC_KEEP-1:0] cyc_sec_lo,
  input  logic [CNT_W-1:0]    cyc_count,
  input  logic                desc_fetch,
  input  logic                fatal_err,
  input  logic                ctx_activated,
  input  logic                pkt_done,
  input  logic [2:0]          pkt_speed,
  input  logic [4:0]          pkt_event,
  output logic                ctx_go,
  output logic                illegal_mode
);
  import irx_ctx_pkg::*;

  logic [REG_W-1:0]  set_m, clr_m;
  logic [MODE_N-1:0] mode_q;
  logic              run_q, wake_q, dead_q, active_q;
  logic              mode_lock;
  logic              match_hit;
  logic [SPD_W-1:0]  speed_q;
  logic [EVT_W-1:0]  event_q;

  assign set_m     = wr_set_en ? wr_set_data : '0;
  assign clr_m     = wr_clr_en ? wr_clr_data : '0;
  assign mode_lock = run_q | active_q;

  // bits that carry no writable state
  logic unused_wr;
  assign unused_wr = ^{set_m[27:16], set_m[14:13], set_m[11:0],
                       clr_m[27:16], clr_m[14:13], clr_m[11:0], match_hit};

  localparam logic [MODE_N-1:0] CME_MASK = MODE_N'(1) << MI_CME;

  irx_mode_bits #(.N(MODE_N), .HW_CLR_MASK(CME_MASK)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock   (mode_lock),
    .set_v  (set_m[MODE_LSB +: MODE_N]),
    .clr_v  (clr_m[MODE_LSB +: MODE_N]),
    .hw_clr (ctx_activated),
    .mode_q (mode_q)
  );

  irx_handshake u_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .sw_set_run   (set_m[BIT_RUN]),
    .sw_clr_run   (clr_m[BIT_RUN]),
    .sw_set_wake  (set_m[BIT_WAKE]),
    .sw_clr_wake  (clr_m[BIT_WAKE]),
    .hw_fetch     (desc_fetch),
    .hw_fatal     (fatal_err),
    .hw_activated (ctx_activated),
    .run_q        (run_q),
    .wake_q       (wake_q),
    .dead_q       (dead_q),
    .active_q     (active_q)
  );

  irx_cycle_gate #(.SEC_KEEP(SEC_KEEP), .CNT_W(CNT_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .match_value (match_value),
    .cyc_sec_lo  (cyc_sec_lo),
    .cyc_count   (cyc_count),
    .run         (run_q),
    .dead        (dead_q),
    .cme         (mode_q[MI_CME]),
    .hit         (match_hit),
    .go          (ctx_go)
  );

  irx_status_fields #(.SW(SPD_W), .EW(EVT_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_done  (pkt_done),
    .pkt_speed (pkt_speed),
    .pkt_event (pkt_event),
    .speed_q   (speed_q),
    .event_q   (event_q)
  );

  always_comb begin
    rd_data                    = '0;
    rd_data[MODE_LSB +: MODE_N] = mode_q;
    rd_data[BIT_RUN]           = run_q;
    rd_data[BIT_WAKE]          = wake_q;
    rd_data[BIT_DEAD]          = dead_q;
    rd_data[BIT_ACTIVE]        = active_q;
    rd_data[SPD_LSB +: SPD_W]  = speed_q;
    rd_data[EVT_LSB +: EVT_W]  = event_q;
  end

  assign illegal_mode = mode_q[MI_MULTI] & ~mode_q[MI_BFILL];

  // R7: a mode write that lands while locked leaves the word's mode field unchanged except the cleared enable
  a_r7_no_mode_change_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lock && !ctx_activated) |=> $stable(rd_data[31:28]));

  // R1: reserved bits never read one
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[27:16] == '0) && (rd_data[14:13] == '0) && (rd_data[9:8] == '0));

endmodule

// File: tb/irx_ctx_ctrl_tb.sv
`timescale 1ns/1ps
module irx_ctx_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_set_en = 1'b0, wr_clr_en = 1'b0;
  logic [31:0] wr_set_data = '0, wr_clr_data = '0;
  logic [31:0] rd_data;
  logic [14:0] match_value = '0;
  logic [1:0]  cyc_sec_lo = '0;
  logic [12:0] cyc_count = '0;
  logic        desc_fetch = 1'b0, fatal_err = 1'b0, ctx_activated = 1'b0, pkt_done = 1'b0;
  logic [2:0]  pkt_speed = '0;
  logic [4:0]  pkt_event = '0;
  logic        ctx_go, illegal_mode;

  always #2 clk = ~clk;

  irx_ctx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_set_en(wr_set_en), .wr_set_data(wr_set_data),
    .wr_clr_en(wr_clr_en), .wr_clr_data(wr_clr_data),
    .rd_data(rd_data), .match_value(match_value),
    .cyc_sec_lo(cyc_sec_lo), .cyc_count(cyc_count),
    .desc_fetch(desc_fetch), .fatal_err(fatal_err),
    .ctx_activated(ctx_activated), .pkt_done(pkt_done),
    .pkt_speed(pkt_speed), .pkt_event(pkt_event),
    .ctx_go(ctx_go), .illegal_mode(illegal_mode)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done_flag = 1'b0;

  // ---------------- reference model ----------------
  bit m_bf, m_hd, m_cm, m_mc, m_run, m_wk, m_dd, m_ac;
  bit [2:0] m_sp;
  bit [4:0] m_ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_bf, m_hd, m_cm, m_mc, m_run, m_wk, m_dd, m_ac} = '0;
      m_sp = '0; m_ev = '0;
    end else begin
      bit [31:0] s, c;
      bit frozen, was_active;
      s = wr_set_en ? wr_set_data : 32'h0;
      c = wr_clr_en ? wr_clr_data : 32'h0;
      frozen = m_run || m_ac;
      was_active = m_ac;
      if (!frozen) begin
        if (s[31]) m_bf = 1; if (c[31]) m_bf = 0;
        if (s[30]) m_hd = 1; if (c[30]) m_hd = 0;
        if (s[29]) m_cm = 1; if (c[29]) m_cm = 0;
        if (s[28]) m_mc = 1; if (c[28]) m_mc = 0;
      end
      if (ctx_activated) m_cm = 0;
      if (soft_rst) begin
        m_run = 0; m_wk = 0; m_dd = 0; m_ac = 0;
      end else begin
        if (s[15]) m_run = 1;
        if (c[15]) m_run = 0;
        if (s[12]) m_wk = 1;
        if (c[12] || desc_fetch) m_wk = 0;
        if (fatal_err) m_dd = 1;
        if (c[15]) m_dd = 0;
        m_ac = (was_active || ctx_activated) && m_run && !m_dd;
      end
      if (pkt_done) begin m_sp = pkt_speed; m_ev = pkt_event; end
    end
  end

  function automatic bit [31:0] model_word();
    bit [31:0] w = 0;
    w[31] = m_bf; w[30] = m_hd; w[29] = m_cm; w[28] = m_mc;
    w[15] = m_run; w[12] = m_wk; w[11] = m_dd; w[10] = m_ac;
    w[7:5] = m_sp; w[4:0] = m_ev;
    return w;
  endfunction

  function automatic bit model_go();
    bit hit = ({cyc_sec_lo, cyc_count} == match_value);
    return m_run && !m_dd && (!m_cm || hit);
  endfunction

  task automatic check(input string t, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // per-clock comparison with the model
  always @(posedge clk) begin
    #1;
    if (!done_flag) begin
      check(tag, "word", rd_data, model_word());
      check("R9", "ctx_go", ctx_go, model_go());
      check("R11", "illegal_mode", illegal_mode, m_mc && !m_bf);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit [31:0] s, input bit [31:0] c, input bit [3:0] hw,
                     input bit pd = 0, input bit [2:0] sp = 0, input bit [4:0] ev = 0);
    @(negedge clk);
    wr_set_en = (s != 0); wr_set_data = s;
    wr_clr_en = (c != 0); wr_clr_data = c;
    {soft_rst, ctx_activated, fatal_err, desc_fetch} = hw;
    pkt_done = pd; pkt_speed = sp; pkt_event = ev;
    @(negedge clk);
    wr_set_en = 0; wr_set_data = 0; wr_clr_en = 0; wr_clr_data = 0;
    {soft_rst, ctx_activated, fatal_err, desc_fetch} = 4'b0;
    pkt_done = 0;
  endtask

  localparam bit [31:0] RUN = 32'h0000_8000, WAKE = 32'h0000_1000;
  localparam bit [31:0] DEAD = 32'h0000_0800, ACT = 32'h0000_0400;
  localparam bit [31:0] BF = 32'h8000_0000, HD = 32'h4000_0000;
  localparam bit [31:0] CM = 32'h2000_0000, MC = 32'h1000_0000;
  localparam bit [3:0] H_FETCH = 4'b0001, H_FATAL = 4'b0010, H_ACT = 4'b0100, H_SRST = 4'b1000;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_flag = 1;
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", "reset word", rd_data, 32'h0);
    check("R1", "reset go", ctx_go, 0);
    rst_n = 1;
    @(negedge clk);

    tag = "R2";
    cyc(RUN | WAKE, 0, 0);          check("R2", "set run+wake", rd_data, 32'h0000_9000);
    cyc(WAKE, WAKE, 0);             check("R2", "clear wins", rd_data, 32'h0000_8000);
    cyc(WAKE, RUN, 0);              check("R2", "clear run keep wake", rd_data, 32'h0000_1000);
    cyc(0, WAKE, 0);                check("R2", "clear wake", rd_data, 32'h0);

    tag = "R3";
    cyc(RUN | WAKE, 0, H_ACT);      check("R3", "run+active", rd_data, 32'h0000_9400);
    cyc(RUN, 0, H_SRST);            check("R3", "soft reset", rd_data, 32'h0);

    tag = "R4";
    cyc(WAKE, 0, 0);
    cyc(WAKE, 0, H_FETCH);          check("R4", "fetch beats set", rd_data, 32'h0);

    tag = "R5";
    cyc(RUN, 0, H_ACT);
    cyc(0, 0, H_FATAL);             check("R5", "fatal", rd_data, 32'h0000_8800);
    cyc(0, DEAD, 0);                check("R5", "dead write ignored", rd_data, 32'h0000_8800);
    cyc(0, RUN, H_FATAL);           check("R5", "run clear beats fatal", rd_data, 32'h0);

    tag = "R6";
    cyc(0, 0, H_ACT);               check("R6", "active needs run", rd_data, 32'h0);
    cyc(RUN, 0, 0);
    cyc(ACT, 0, H_ACT);             check("R6", "active set", rd_data, 32'h0000_8400);
    cyc(0, ACT, 0);                 check("R6", "active write ignored", rd_data, 32'h0000_8400);
    cyc(0, RUN, 0);                 check("R6", "active drops", rd_data, 32'h0);

    tag = "R7";
    cyc(BF | HD, 0, 0);             check("R7", "modes writable", rd_data, 32'hC000_0000);
    cyc(RUN, 0, 0);
    cyc(MC, BF, 0);                 check("R7", "modes locked", rd_data, 32'hC000_8000);
    cyc(0, RUN, 0);
    cyc(0, HD, 0);                  check("R7", "unlocked again", rd_data, 32'h8000_0000);

    tag = "R8";
    cyc(CM, 0, 0);                  check("R8", "cme set", rd_data, 32'hA000_0000);
    cyc(RUN, 0, H_ACT);             check("R8", "cme cleared", rd_data, 32'h8000_8400);
    cyc(0, RUN, 0);
    cyc(CM, 0, H_ACT);              check("R8", "hw clear beats set", rd_data, 32'h8000_0000);

    tag = "R9";
    @(negedge clk);
    match_value = {2'b01, 13'd100}; cyc_sec_lo = 2'b01; cyc_count = 13'd99;
    cyc(CM | RUN, 0, 0);
    #1 check("R9", "gated miss", ctx_go, 0);
    @(negedge clk); cyc_count = 13'd100;
    #1 check("R9", "gated hit", ctx_go, 1);
    @(negedge clk); cyc_sec_lo = 2'b00;
    #1 check("R9", "seconds mismatch", ctx_go, 0);
    cyc(0, RUN, 0);
    cyc(0, CM, 0);
    cyc(RUN, 0, 0);
    #1 check("R9", "ungated go", ctx_go, 1);
    cyc(0, 0, H_FATAL);
    #1 check("R9", "dead stops go", ctx_go, 0);
    cyc(0, RUN, 0);

    tag = "R10";
    cyc(0, 0, 0, 1, 3'b010, 5'h11); check("R10", "load", rd_data[7:0], 8'h51);
    cyc(32'hFF, 32'h0, 0);          check("R10", "set write ignored", rd_data[7:0], 8'h51);
    cyc(0, 32'hFF, 0);              check("R10", "clr write ignored", rd_data[7:0], 8'h51);
    cyc(0, 0, 0, 1, 3'b001, 5'h03); check("R10", "reload", rd_data[7:0], 8'h23);

    tag = "R11";
    cyc(MC, BF | HD, 0);
    check("R11", "multi without fill", illegal_mode, 1);
    cyc(BF, 0, 0);
    check("R11", "legal combination", illegal_mode, 0);
    check("R1", "reserved bits", rd_data & 32'h0FFF_6300, 0);

    // random collisions, compared every clock against the model
    tag = "R2/R7 random";
    match_value = {2'b01, 13'd5};
    for (int i = 0; i < 600; i++) begin
      bit [31:0] msk = 32'hF000_9C00 | 32'h0FFF_63FF;
      @(negedge clk);
      wr_set_en   = ($urandom_range(0, 2) == 0);
      wr_set_data = $urandom() & msk;
      wr_clr_en   = ($urandom_range(0, 3) == 0);
      wr_clr_data = $urandom() & msk & 32'hFFFF_7FFF | (($urandom_range(0, 5) == 0) ? RUN : 0);
      desc_fetch    = ($urandom_range(0, 3) == 0);
      fatal_err     = ($urandom_range(0, 15) == 0);
      ctx_activated = ($urandom_range(0, 3) == 0);
      soft_rst      = ($urandom_range(0, 40) == 0);
      pkt_done      = ($urandom_range(0, 2) == 0);
      pkt_speed     = 3'($urandom());
      pkt_event     = 5'($urandom());
      cyc_sec_lo    = 2'($urandom_range(0, 1));
      cyc_count     = 13'($urandom_range(3, 7));
    end
    @(negedge clk);
    {wr_set_en, wr_clr_en, desc_fetch, fatal_err, ctx_activated, soft_rst, pkt_done} = '0;
    repeat (2) @(negedge clk);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule